// File: doc/BRIEF.md
# Over-discharge guard and sleep sequencer

This block watches four digitized cell voltages and controls the gates of a pack's discharge and charge switches. If any cell stays under a selectable under-voltage level for longer than a programmed number of ticks, it opens the discharge path and drops into a sleep state. In sleep both switches are off and the regulator enable is low. The host can also request sleep at any time while the block is awake.

Leaving sleep is a strict ordered gate and never an automatic release. First a wake event puts the block into an awake but protected state. Next the host must turn the charge switch on. Then every cell must stay above a release level for a programmed release time. Only after that does a host write that turns the discharge switch on take effect. The switch controls are active-high "off" levels, so a 1 on an output opens that switch. All outputs are registered, and a change on an input shows on the outputs one clock edge later.

Top module: `dischg_guard_seq`

## Requirements
- R1: In the run state (code 0), if any cell is under the threshold on LIMIT+1 consecutive cycles with `tick_i` high, where LIMIT is `det_dly_i`, the block enters sleep (code 1) and sets `dsg_off_o` to 1. After only LIMIT such cycles it is still running.
- R2: The under-voltage threshold is UV_BASE + `uv_sel_i`*UV_STEP. A cell counts as under only when its code is strictly below the threshold. A code equal to the threshold does not count.
- R3: A tick cycle in run state on which no cell is under the threshold clears the detection count. A later detection again needs LIMIT+1 consecutive under ticks.
- R4: In sleep, `dsg_off_o` = 1, `chg_off_o` = 1 and `reg_en_o` = 0.
- R5: A `host_sleep_i` pulse in any awake state (codes 0, 2, 3, 4) moves the block to sleep.
- R6: `wake_i` in sleep moves the block to protected state (code 2) with both off outputs at 1 and `reg_en_o` = 1. Outside sleep, `wake_i` has no effect.
- R7: In protected state, a discharge-on write is ignored. A charge-on write moves the block to qualifying state (code 3) with `chg_off_o` = 0 and `dsg_off_o` = 1.
- R8: In qualifying state, after `rel_dly_i`+1 consecutive tick cycles with every cell strictly above `rel_thr_i`, the block moves to ready state (code 4). A tick cycle on which any cell is at or below `rel_thr_i` restarts the count from zero.
- R9: A discharge-on write is ignored in qualifying state. In ready state it returns the block to run state with both off outputs at 0.
- R10: A charge-off write in qualifying or ready state returns the block to protected state with `chg_off_o` = 1.
- R11: In run state, host writes set the switches directly: `chg_off_o` = !`host_chg_on_i` and `dsg_off_o` = !`host_dsg_on_i`.
- R12: After reset the block is in run state with `chg_off_o` = 0, `dsg_off_o` = 0 and `reg_en_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cells_i | input | CELLS*CODE_W | Packed cell codes, cell 0 in the low bits |
| uv_sel_i | input | 2 | Under-voltage threshold select |
| rel_thr_i | input | CODE_W | Release threshold |
| det_dly_i | input | CNT_W | Detection delay in ticks |
| rel_dly_i | input | CNT_W | Release delay in ticks |
| tick_i | input | 1 | Timebase tick |
| wake_i | input | 1 | Wake event |
| host_sleep_i | input | 1 | Host sleep request pulse |
| host_chg_wr_i | input | 1 | Host charge switch write strobe |
| host_chg_on_i | input | 1 | Value written: 1 turns charge switch on |
| host_dsg_wr_i | input | 1 | Host discharge switch write strobe |
| host_dsg_on_i | input | 1 | Value written: 1 turns discharge switch on |
| dsg_off_o | output | 1 | Discharge switch off level |
| chg_off_o | output | 1 | Charge switch off level |
| reg_en_o | output | 1 | Regulator enable |
| state_o | output | 3 | State code: 0 run, 1 sleep, 2 protected, 3 qualifying, 4 ready |

## Verification
The bench builds the block with 8-bit codes, 4-bit delay counters, UV_BASE 40 and UV_STEP 10, and drives the tick on every cycle. This makes each delay equal to a cycle count. It sweeps all four threshold selects against delays 0 to 3, with the under-voltage cell rotated across the four cells. Each case places a cell exactly on the threshold and then one code below it. Every sweep case then walks the full exit sequence with a matching release delay. Separate cases cover an interrupted detection, a restarted release, charge-off fallback, host sleep from run and from protected state, and a wake outside sleep.

// File: rtl/dischg_pkg.sv
package dischg_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_PROT  = 3'd2,
    ST_QUAL  = 3'd3,
    ST_READY = 3'd4
  } guard_state_t;
endpackage

// File: rtl/dischg_cell_cmp.sv
module dischg_cell_cmp #(
  parameter int CELLS   = 4,
  parameter int CODE_W  = 12,
  parameter int UV_BASE = 2500,
  parameter int UV_STEP = 100
) (
  input  logic [CELLS*CODE_W-1:0] cells_i,
  input  logic [1:0]              uv_sel_i,
  input  logic [CODE_W-1:0]       rel_thr_i,
  output logic                    any_under_o,
  output logic                    all_above_o
);
  localparam int NSEL = 4;

  logic [CODE_W-1:0] thr_tab [NSEL];
  logic [CODE_W-1:0] uv_thr;
  logic [CELLS-1:0]  under;
  logic [CELLS-1:0]  above;

  // threshold table computed from base and step
  for (genvar s = 0; s < NSEL; s++) begin : g_thr
    assign thr_tab[s] = CODE_W'(UV_BASE + s * UV_STEP);
  end

  assign uv_thr = thr_tab[uv_sel_i];

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [CODE_W-1:0] code;
    assign code     = cells_i[c*CODE_W +: CODE_W];
    assign under[c] = (code < uv_thr);
    assign above[c] = (code > rel_thr_i);
  end

  assign any_under_o = |under;
  assign all_above_o = &above;
endmodule

// File: rtl/dischg_delay_timer.sv
module dischg_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             cond_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit    = (cnt_q == limit_i);
  assign done_o = en_i && cond_i && tick_i && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!en_i || !cond_i) begin
      cnt_q <= '0;
    end else if (tick_i && !hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3 / R8: a broken qualifying condition restarts the count
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    (en_i && !cond_i) |=> (cnt_q == '0));

  // R1: completion with a nonzero limit needs the condition held before
  a_r1_done_history: assert property (@(posedge clk) disable iff (rst)
    (done_o && limit_i != '0 && $past(limit_i) == limit_i && !$past(rst))
      |-> ($past(cond_i) && $past(en_i)));
endmodule

// File: rtl/dischg_seq_fsm.sv
module dischg_seq_fsm
  import dischg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trip_i,
  input  logic       rel_done_i,
  input  logic       wake_i,
  input  logic       host_sleep_i,
  input  logic       host_chg_wr_i,
  input  logic       host_chg_on_i,
  input  logic       host_dsg_wr_i,
  input  logic       host_dsg_on_i,
  output logic       run_o,
  output logic       qual_o,
  output logic       dsg_off_o,
  output logic       chg_off_o,
  output logic       reg_en_o,
  output logic [2:0] state_o
);
  guard_state_t st_q, st_d;
  logic chg_on_q, chg_on_d;
  logic dsg_on_q, dsg_on_d;
  logic dsg_off_d, chg_off_d, reg_en_d;

  always_comb begin
    st_d     = st_q;
    chg_on_d = chg_on_q;
    dsg_on_d = dsg_on_q;
    unique case (st_q)
      ST_RUN: begin
        if (trip_i || host_sleep_i) begin
          st_d = ST_SLEEP;
        end else begin
          if (host_chg_wr_i) chg_on_d = host_chg_on_i;
          if (host_dsg_wr_i) dsg_on_d = host_dsg_on_i;
        end
      end
      ST_SLEEP: begin
        if (wake_i) st_d = ST_PROT;
      end
      ST_PROT: begin
        if (host_sleep_i)                         st_d = ST_SLEEP;
        else if (host_chg_wr_i && host_chg_on_i)  st_d = ST_QUAL;
      end
      ST_QUAL: begin
        if (host_sleep_i)                         st_d = ST_SLEEP;
        else if (host_chg_wr_i && !host_chg_on_i) st_d = ST_PROT;
        else if (rel_done_i)                      st_d = ST_READY;
      end
      ST_READY: begin
        if (host_sleep_i)                         st_d = ST_SLEEP;
        else if (host_chg_wr_i && !host_chg_on_i) st_d = ST_PROT;
        else if (host_dsg_wr_i && host_dsg_on_i) begin
          st_d     = ST_RUN;
          chg_on_d = 1'b1;
          dsg_on_d = 1'b1;
        end
      end
      default: st_d = ST_SLEEP;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_RUN: begin
        dsg_off_d = !dsg_on_d; chg_off_d = !chg_on_d; reg_en_d = 1'b1;
      end
      ST_SLEEP: begin
        dsg_off_d = 1'b1; chg_off_d = 1'b1; reg_en_d = 1'b0;
      end
      ST_PROT: begin
        dsg_off_d = 1'b1; chg_off_d = 1'b1; reg_en_d = 1'b1;
      end
      default: begin
        dsg_off_d = 1'b1; chg_off_d = 1'b0; reg_en_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_RUN;
      chg_on_q  <= 1'b1;
      dsg_on_q  <= 1'b1;
      dsg_off_o <= 1'b0;
      chg_off_o <= 1'b0;
      reg_en_o  <= 1'b1;
    end else begin
      st_q      <= st_d;
      chg_on_q  <= chg_on_d;
      dsg_on_q  <= dsg_on_d;
      dsg_off_o <= dsg_off_d;
      chg_off_o <= chg_off_d;
      reg_en_o  <= reg_en_d;
    end
  end

  assign run_o   = (st_q == ST_RUN);
  assign qual_o  = (st_q == ST_QUAL);
  assign state_o = st_q;

  // R4: sleep holds both switches off and the regulator down
  a_r4_sleep_levels: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP) |-> (dsg_off_o && chg_off_o && !reg_en_o));

  // R9: discharge only turns on from run or ready
  a_r9_dsg_gate: assert property (@(posedge clk) disable iff (rst)
    (!dsg_off_o && $past(dsg_off_o))
      |-> ($past(st_q) == ST_RUN || $past(st_q) == ST_READY));

  // R6: wake from sleep lands in the protected state
  a_r6_wake_prot: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && wake_i) |=> (st_q == ST_PROT));
endmodule

// File: rtl/dischg_guard_seq.sv
module dischg_guard_seq #(
  parameter int CELLS   = 4,
  parameter int CODE_W  = 12,
  parameter int CNT_W   = 16,
  parameter int UV_BASE = 2500,
  parameter int UV_STEP = 100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CELLS*CODE_W-1:0] cells_i,
  input  logic [1:0]              uv_sel_i,
  input  logic [CODE_W-1:0]       rel_thr_i,
  input  logic [CNT_W-1:0]        det_dly_i,
  input  logic [CNT_W-1:0]        rel_dly_i,
  input  logic                    tick_i,
  input  logic                    wake_i,
  input  logic                    host_sleep_i,
  input  logic                    host_chg_wr_i,
  input  logic                    host_chg_on_i,
  input  logic                    host_dsg_wr_i,
  input  logic                    host_dsg_on_i,
  output logic                    dsg_off_o,
  output logic                    chg_off_o,
  output logic                    reg_en_o,
  output logic [2:0]              state_o
);
  logic any_under, all_above;
  logic run, qual, trip, rel_done;

  dischg_cell_cmp #(
    .CELLS(CELLS), .CODE_W(CODE_W), .UV_BASE(UV_BASE), .UV_STEP(UV_STEP)
  ) cmp_i (
    .cells_i(cells_i), .uv_sel_i(uv_sel_i), .rel_thr_i(rel_thr_i),
    .any_under_o(any_under), .all_above_o(all_above)
  );

  dischg_delay_timer #(.CNT_W(CNT_W)) det_tmr_i (
    .clk(clk), .rst(rst), .en_i(run), .cond_i(any_under), .tick_i(tick_i),
    .limit_i(det_dly_i), .done_o(trip)
  );

  dischg_delay_timer #(.CNT_W(CNT_W)) rel_tmr_i (
    .clk(clk), .rst(rst), .en_i(qual), .cond_i(all_above), .tick_i(tick_i),
    .limit_i(rel_dly_i), .done_o(rel_done)
  );

  dischg_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .trip_i(trip), .rel_done_i(rel_done),
    .wake_i(wake_i), .host_sleep_i(host_sleep_i),
    .host_chg_wr_i(host_chg_wr_i), .host_chg_on_i(host_chg_on_i),
    .host_dsg_wr_i(host_dsg_wr_i), .host_dsg_on_i(host_dsg_on_i),
    .run_o(run), .qual_o(qual), .dsg_off_o(dsg_off_o), .chg_off_o(chg_off_o),
    .reg_en_o(reg_en_o), .state_o(state_o)
  );
endmodule

// File: tb/dischg_guard_seq_tb_top.sv
module dischg_guard_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 4;
  localparam int CW    = 8;
  localparam int NW    = 4;
  localparam int BASE  = 40;
  localparam int STEP  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CELLS*CW-1:0] cells;
  logic [1:0] sel;
  logic [CW-1:0] rthr;
  logic [NW-1:0] ddly, rdly;
  logic tick, wake, hsleep, cwr, con, dwr, don;
  logic dsg_off, chg_off, reg_en;
  logic [2:0] st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dischg_guard_seq #(
    .CELLS(CELLS), .CODE_W(CW), .CNT_W(NW), .UV_BASE(BASE), .UV_STEP(STEP)
  ) dut_i (
    .clk(clk), .rst(rst), .cells_i(cells), .uv_sel_i(sel), .rel_thr_i(rthr),
    .det_dly_i(ddly), .rel_dly_i(rdly), .tick_i(tick), .wake_i(wake),
    .host_sleep_i(hsleep), .host_chg_wr_i(cwr), .host_chg_on_i(con),
    .host_dsg_wr_i(dwr), .host_dsg_on_i(don),
    .dsg_off_o(dsg_off), .chg_off_o(chg_off), .reg_en_o(reg_en), .state_o(st)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_all(input int v);
    for (int c = 0; c < CELLS; c++) cells[c*CW +: CW] = CW'(v);
  endtask

  // walk the exit sequence from sleep with release delay lr
  task automatic recover(input int lr);
    set_all(200); rthr = 8'd100; rdly = NW'(lr); tick = 1'b0;
    wake = 1'b1; step(); wake = 1'b0;
    chk("R6 state", st, 2); chk("R6 dsg_off", dsg_off, 1);
    chk("R6 chg_off", chg_off, 1); chk("R6 reg_en", reg_en, 1);
    dwr = 1'b1; don = 1'b1; step(); dwr = 1'b0;
    chk("R7 dsg ignored", st, 2); chk("R7 dsg_off", dsg_off, 1);
    cwr = 1'b1; con = 1'b1; step(); cwr = 1'b0;
    chk("R7 qual", st, 3); chk("R7 chg_off", chg_off, 0);
    dwr = 1'b1; don = 1'b1; step(); dwr = 1'b0;
    chk("R9 dsg ignored in qual", st, 3); chk("R9 dsg_off", dsg_off, 1);
    tick = 1'b1;
    repeat (lr) step();
    chk("R8 still qual", st, 3);
    step();
    chk("R8 ready", st, 4);
    tick = 1'b0;
    dwr = 1'b1; don = 1'b1; step(); dwr = 1'b0;
    chk("R9 run", st, 0); chk("R9 dsg_off", dsg_off, 0);
    chk("R9 chg_off", chg_off, 0);
  endtask

  initial begin
    set_all(200); sel = 2'd0; rthr = 8'd100; ddly = '0; rdly = '0;
    tick = 1'b0; wake = 1'b0; hsleep = 1'b0; cwr = 1'b0; con = 1'b0;
    dwr = 1'b0; don = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R12 state", st, 0); chk("R12 dsg_off", dsg_off, 0);
    chk("R12 chg_off", chg_off, 0); chk("R12 reg_en", reg_en, 1);

    // R1 / R2 / R4 sweep
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        int thr;
        int idx;
        thr = BASE + STEP * s;
        idx = (s + l) % CELLS;
        set_all(200); sel = 2'(s); ddly = NW'(l); tick = 1'b1;
        cells[idx*CW +: CW] = CW'(thr);
        step();
        chk("R2 equal not under", st, 0);
        cells[idx*CW +: CW] = CW'(thr - 1);
        repeat (l) step();
        chk("R1 not yet", st, 0);
        step();
        chk("R1 trip", st, 1); chk("R1 dsg_off", dsg_off, 1);
        chk("R4 chg_off", chg_off, 1); chk("R4 reg_en", reg_en, 0);
        recover(l);
      end
    end

    // R3 interrupted detection
    sel = 2'd1; ddly = 4'd3; tick = 1'b1; set_all(200);
    cells[CW +: CW] = 8'd49;
    repeat (2) step();
    cells[CW +: CW] = 8'd50; step();
    cells[CW +: CW] = 8'd49;
    repeat (3) step();
    chk("R3 count cleared", st, 0);
    step();
    chk("R3 trip", st, 1);
    recover(1);

    // R11 direct control in run
    dwr = 1'b1; don = 1'b0; step(); dwr = 1'b0;
    chk("R11 dsg off", dsg_off, 1);
    cwr = 1'b1; con = 1'b0; step(); cwr = 1'b0;
    chk("R11 chg off", chg_off, 1);
    dwr = 1'b1; don = 1'b1; cwr = 1'b1; con = 1'b1; step();
    dwr = 1'b0; cwr = 1'b0;
    chk("R11 dsg on", dsg_off, 0); chk("R11 chg on", chg_off, 0);

    // R6 wake ignored in run
    wake = 1'b1; step(); wake = 1'b0;
    chk("R6 wake ignored", st, 0);

    // R5 host sleep from run and from protected
    hsleep = 1'b1; step(); hsleep = 1'b0;
    chk("R5 sleep from run", st, 1); chk("R5 reg_en", reg_en, 0);
    wake = 1'b1; step(); wake = 1'b0;
    chk("R5 woken", st, 2);
    hsleep = 1'b1; step(); hsleep = 1'b0;
    chk("R5 sleep from prot", st, 1);

    // R8 restart, R10 fallback
    set_all(200); rthr = 8'd100; rdly = 4'd2; tick = 1'b0;
    wake = 1'b1; step(); wake = 1'b0;
    cwr = 1'b1; con = 1'b1; step(); cwr = 1'b0;
    chk("R7 qual", st, 3);
    tick = 1'b1;
    repeat (2) step();
    cells[0 +: CW] = 8'd100; step();
    cells[0 +: CW] = 8'd200;
    repeat (2) step();
    chk("R8 restarted", st, 3);
    step();
    chk("R8 ready after restart", st, 4);
    tick = 1'b0;
    cwr = 1'b1; con = 1'b0; step(); cwr = 1'b0;
    chk("R10 back to prot", st, 2); chk("R10 chg_off", chg_off, 1);
    cwr = 1'b1; con = 1'b1; step(); cwr = 1'b0;
    cwr = 1'b1; con = 1'b0; step(); cwr = 1'b0;
    chk("R10 from qual", st, 2);
    cwr = 1'b1; con = 1'b1; step(); cwr = 1'b0;
    tick = 1'b1;
    repeat (3) step();
    chk("R8 ready", st, 4);
    tick = 1'b0;
    dwr = 1'b1; don = 1'b1; step(); dwr = 1'b0;
    chk("R9 run", st, 0); chk("R9 dsg_off", dsg_off, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule